// File: doc/BRIEF.md
# Dual 16KB Window RAM Mapper

This block sits between an 8-bit CPU bus with a 16-bit address and the memory devices of a small system. It cuts the 64KB CPU space into four 16KB quadrants by looking only at the two top address bits. The two lowest quadrants are windows into two separate large RAM devices. Each window has its own bank register. That register supplies the upper address lines of its RAM, so each device offers 16 banks of 16KB. The third quadrant holds the peripherals and the top quadrant holds the ROM.

Both bank registers live at the start of the peripheral quadrant and can be read back. Interrupt code can therefore save them, switch banks and restore them. The block also produces per-device output-enable and write-enable strobes. Each strobe is qualified by the bus read/write line and by the phase-2 clock. A write is captured on the system clock edge during phase 2. The new bank value appears on the RAM address lines from the next cycle.

Top module: `dual_window_mapper`

## Requirements
- R1: The region is chosen by address bits 15:14 alone. Value 0 selects RAM window A, 1 selects RAM window B, 2 selects the peripheral region and 3 selects the ROM. At most one device strobe is active at a time.
- R2: The RAM A address is the 18-bit value {bank A[3:0], A13:A0}, with A13:A0 taken straight from the CPU address.
- R3: The RAM B address is the 18-bit value {bank B[3:0], A13:A0}.
- R4: While reset is active, both bank registers hold 4'b1111.
- R5: A write during phase 2 to 0x8000 loads bank A from data bits 3:0, and a write to 0x8001 loads bank B. Data bits 7:4 are ignored. The new value is on the RAM address from the next clock edge on.
- R6: A phase-2 read of 0x8000 or 0x8001 raises cpu_rdata_en. cpu_rdata then carries the chosen bank in bits 3:0, and bits 7:4 are zero.
- R7: Output enables are active only on read cycles (cpu_rnw=1) during phase 2. Write enables are active only on write cycles (cpu_rnw=0) during phase 2.
- R8: A write cycle in the ROM quadrant activates no strobe.
- R9: An access to 0x8000 or 0x8001 raises no peripheral strobe. Every other peripheral-quadrant address raises io_oe or io_we according to R7.
- R10: A bank register keeps its value across reads, across writes outside phase 2 and across writes to any other address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | CPU address |
| cpu_rnw | input | 1 | 1 = read cycle, 0 = write cycle |
| cpu_phi2 | input | 1 | Phase-2 qualifier |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | Bank register read data |
| cpu_rdata_en | output | 1 | Mapper drives the data bus |
| ram_a_addr | output | 18 | Physical address of RAM A |
| ram_a_oe | output | 1 | RAM A output enable |
| ram_a_we | output | 1 | RAM A write enable |
| ram_b_addr | output | 18 | Physical address of RAM B |
| ram_b_oe | output | 1 | RAM B output enable |
| ram_b_we | output | 1 | RAM B write enable |
| rom_oe | output | 1 | ROM output enable |
| io_oe | output | 1 | Peripheral read strobe |
| io_we | output | 1 | Peripheral write strobe |

## Verification
The bench steps both bank registers through all sixteen values in opposite orders and checks the RAM addresses and readback each time. A swapped register slot would show up as mirrored banks, and a design that kept data bits 7:4 would show up as nonzero upper readback. It then sweeps every quadrant at its edge offsets, including the two register addresses and the quadrant boundaries, under every combination of read/write and phase 2. A bench-side model of the registers follows each vector. This catches strobes leaking outside phase 2, a write enable on ROM, peripheral strobes on the register slots, and bank loads from mistimed writes. A reset value other than all ones fails the first readback.

// File: rtl/mapper_pkg.sv
package mapper_pkg;
   typedef enum logic [1:0] {
      RGN_WIN_A = 2'd0,
      RGN_WIN_B = 2'd1,
      RGN_IO    = 2'd2,
      RGN_ROM   = 2'd3
   } region_t;

   typedef struct packed {
      logic a_oe;
      logic a_we;
      logic b_oe;
      logic b_we;
      logic rom_oe;
      logic io_oe;
      logic io_we;
      logic reg_rd;
   } strobes_t;
endpackage

// File: rtl/mapper_decode.sv
module mapper_decode
   import mapper_pkg::*;
#(
   parameter int ADDR_W   = 16,
   parameter int N_WIN    = 2,
   parameter logic [ADDR_W-1:0] REG_BASE = 16'h8000
) (
   input  logic [ADDR_W-1:0] addr,
   output region_t           region,
   output logic [N_WIN-1:0]  reg_hit
);
   localparam int RGN_LSB = ADDR_W - 2;

   assign region = region_t'(addr[ADDR_W-1:RGN_LSB]);

   for (genvar i = 0; i < N_WIN; i++) begin : g_hit
      localparam logic [ADDR_W-1:0] SLOT = REG_BASE + ADDR_W'(i);
      assign reg_hit[i] = (addr == SLOT);
   end
endmodule

// File: rtl/mapper_bank_reg.sv
module mapper_bank_reg #(
   parameter int BANK_W = 4,
   parameter logic [BANK_W-1:0] RST_VAL = '1,
   parameter bit SYNC_RESET = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [BANK_W-1:0] wr_val,
   output logic [BANK_W-1:0] bank
);
   if (SYNC_RESET) begin : g_sync
      always_ff @(posedge clk) begin
         if (!rst_n)     bank <= RST_VAL;
         else if (wr_en) bank <= wr_val;
      end
   end else begin : g_async
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)     bank <= RST_VAL;
         else if (wr_en) bank <= wr_val;
      end
   end
endmodule

// File: rtl/mapper_strobe.sv
module mapper_strobe
   import mapper_pkg::*;
#(
   parameter int N_WIN = 2
) (
   input  region_t          region,
   input  logic [N_WIN-1:0] reg_hit,
   input  logic             rnw,
   input  logic             phi2,
   output strobes_t         stb
);
   logic rd, wr, any_reg;

   always_comb begin
      rd      = phi2 & rnw;
      wr      = phi2 & ~rnw;
      any_reg = |reg_hit;
      stb.a_oe   = (region == RGN_WIN_A) & rd;
      stb.a_we   = (region == RGN_WIN_A) & wr;
      stb.b_oe   = (region == RGN_WIN_B) & rd;
      stb.b_we   = (region == RGN_WIN_B) & wr;
      stb.rom_oe = (region == RGN_ROM) & rd;
      stb.io_oe  = (region == RGN_IO) & ~any_reg & rd;
      stb.io_we  = (region == RGN_IO) & ~any_reg & wr;
      stb.reg_rd = any_reg & rd;
   end
endmodule

// File: rtl/dual_window_mapper.sv
module dual_window_mapper
   import mapper_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 8,
   parameter int BANK_W = 4,
   parameter logic [BANK_W-1:0] BANK_RST = '1,
   parameter logic [ADDR_W-1:0] REG_BASE = 16'h8000,
   parameter bit SYNC_RESET = 1'b0
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [ADDR_W-1:0]          cpu_addr,
   input  logic                       cpu_rnw,
   input  logic                       cpu_phi2,
   input  logic [DATA_W-1:0]          cpu_wdata,
   output logic [DATA_W-1:0]          cpu_rdata,
   output logic                       cpu_rdata_en,
   output logic [BANK_W+ADDR_W-3:0]   ram_a_addr,
   output logic                       ram_a_oe,
   output logic                       ram_a_we,
   output logic [BANK_W+ADDR_W-3:0]   ram_b_addr,
   output logic                       ram_b_oe,
   output logic                       ram_b_we,
   output logic                       rom_oe,
   output logic                       io_oe,
   output logic                       io_we
);
   localparam int N_WIN = 2;
   localparam int WIN_W = ADDR_W - 2;

   if (ADDR_W < 4) begin : g_bad_addr
      $error("ADDR_W too small for quadrant decode");
   end
   if (DATA_W < BANK_W) begin : g_bad_data
      $error("bank register wider than data bus");
   end
   if (REG_BASE[ADDR_W-1:ADDR_W-2] != 2'b10) begin : g_bad_base
      $error("bank registers must lie in the peripheral quadrant");
   end

   region_t          region;
   logic [N_WIN-1:0] reg_hit;
   strobes_t         stb;
   logic [BANK_W-1:0] bank [N_WIN];

   mapper_decode #(.ADDR_W(ADDR_W), .N_WIN(N_WIN), .REG_BASE(REG_BASE)) u_dec (
      .addr    (cpu_addr),
      .region  (region),
      .reg_hit (reg_hit)
   );

   mapper_strobe #(.N_WIN(N_WIN)) u_stb (
      .region  (region),
      .reg_hit (reg_hit),
      .rnw     (cpu_rnw),
      .phi2    (cpu_phi2),
      .stb     (stb)
   );

   for (genvar i = 0; i < N_WIN; i++) begin : g_bank
      logic wr_en;
      assign wr_en = reg_hit[i] & cpu_phi2 & ~cpu_rnw;
      mapper_bank_reg #(.BANK_W(BANK_W), .RST_VAL(BANK_RST), .SYNC_RESET(SYNC_RESET)) u_reg (
         .clk    (clk),
         .rst_n  (rst_n),
         .wr_en  (wr_en),
         .wr_val (cpu_wdata[BANK_W-1:0]),
         .bank   (bank[i])
      );
   end

   always_comb begin
      cpu_rdata = '0;
      for (int i = 0; i < N_WIN; i++) begin
         if (reg_hit[i]) cpu_rdata[BANK_W-1:0] = bank[i];
      end
   end

   assign cpu_rdata_en = stb.reg_rd;
   assign ram_a_addr   = {bank[0], cpu_addr[WIN_W-1:0]};
   assign ram_b_addr   = {bank[1], cpu_addr[WIN_W-1:0]};
   assign ram_a_oe     = stb.a_oe;
   assign ram_a_we     = stb.a_we;
   assign ram_b_oe     = stb.b_oe;
   assign ram_b_we     = stb.b_we;
   assign rom_oe       = stb.rom_oe;
   assign io_oe        = stb.io_oe;
   assign io_we        = stb.io_we;
endmodule

// File: rtl/mapper_checker.sv
module mapper_checker #(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 8,
   parameter int BANK_W = 4,
   parameter logic [ADDR_W-1:0] REG_BASE = 16'h8000
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic [ADDR_W-1:0]        cpu_addr,
   input logic                     cpu_rnw,
   input logic                     cpu_phi2,
   input logic [DATA_W-1:0]        cpu_wdata,
   input logic [DATA_W-1:0]        cpu_rdata,
   input logic                     cpu_rdata_en,
   input logic [BANK_W+ADDR_W-3:0] ram_a_addr,
   input logic                     ram_a_oe,
   input logic                     ram_a_we,
   input logic [BANK_W+ADDR_W-3:0] ram_b_addr,
   input logic                     ram_b_oe,
   input logic                     ram_b_we,
   input logic                     rom_oe,
   input logic                     io_oe,
   input logic                     io_we
);
   localparam int WIN_W = ADDR_W - 2;
   localparam int TOP   = BANK_W + WIN_W - 1;

   logic wr_a, wr_b, any_we, any_oe;
   assign wr_a   = cpu_phi2 && !cpu_rnw && (cpu_addr == REG_BASE);
   assign wr_b   = cpu_phi2 && !cpu_rnw && (cpu_addr == REG_BASE + ADDR_W'(1));
   assign any_we = ram_a_we | ram_b_we | io_we;
   assign any_oe = ram_a_oe | ram_b_oe | rom_oe | io_oe | cpu_rdata_en;

   a_r1_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({ram_a_oe, ram_a_we, ram_b_oe, ram_b_we, rom_oe, io_oe, io_we, cpu_rdata_en}));

   a_r2_low_bits: assert property (@(posedge clk) disable iff (!rst_n)
      ram_a_addr[WIN_W-1:0] == cpu_addr[WIN_W-1:0]);

   a_r4_reset_ones: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (ram_a_addr[TOP:WIN_W] == '1) && (ram_b_addr[TOP:WIN_W] == '1));

   a_r5_load_a: assert property (@(posedge clk) disable iff (!rst_n)
      wr_a |=> ram_a_addr[TOP:WIN_W] == $past(cpu_wdata[BANK_W-1:0]));

   a_r6_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_rdata_en |-> cpu_rdata[DATA_W-1:BANK_W] == '0);

   a_r7_we_qualified: assert property (@(posedge clk) disable iff (!rst_n)
      any_we |-> cpu_phi2 && !cpu_rnw);

   a_r7_oe_qualified: assert property (@(posedge clk) disable iff (!rst_n)
      any_oe |-> cpu_phi2 && cpu_rnw);

   a_r8_rom_write_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (!cpu_rnw && cpu_addr[ADDR_W-1:ADDR_W-2] == 2'b11) |-> !(any_we || any_oe));

   a_r9_reg_no_io: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_rdata_en |-> !io_oe && !io_we);

   a_r10_hold_b: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_b |=> $stable(ram_b_addr[TOP:WIN_W]));
endmodule

bind dual_window_mapper mapper_checker #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BANK_W(BANK_W), .REG_BASE(REG_BASE)
) u_chk (
   .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_rnw(cpu_rnw),
   .cpu_phi2(cpu_phi2), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
   .cpu_rdata_en(cpu_rdata_en), .ram_a_addr(ram_a_addr), .ram_a_oe(ram_a_oe),
   .ram_a_we(ram_a_we), .ram_b_addr(ram_b_addr), .ram_b_oe(ram_b_oe),
   .ram_b_we(ram_b_we), .rom_oe(rom_oe), .io_oe(io_oe), .io_we(io_we)
);

// File: tb/tb_dual_window_mapper.sv
module tb_dual_window_mapper;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] cpu_addr = '0;
   logic        cpu_rnw = 1'b1;
   logic        cpu_phi2 = 1'b0;
   logic [7:0]  cpu_wdata = '0;
   logic [7:0]  cpu_rdata;
   logic        cpu_rdata_en;
   logic [17:0] ram_a_addr, ram_b_addr;
   logic        ram_a_oe, ram_a_we, ram_b_oe, ram_b_we, rom_oe, io_oe, io_we;

   int vectors = 0;
   int fails = 0;
   logic [3:0] mdl_a, mdl_b;

   always #10 clk = ~clk;

   dual_window_mapper dut (
      .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_rnw(cpu_rnw),
      .cpu_phi2(cpu_phi2), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
      .cpu_rdata_en(cpu_rdata_en), .ram_a_addr(ram_a_addr), .ram_a_oe(ram_a_oe),
      .ram_a_we(ram_a_we), .ram_b_addr(ram_b_addr), .ram_b_oe(ram_b_oe),
      .ram_b_we(ram_b_we), .rom_oe(rom_oe), .io_oe(io_oe), .io_we(io_we)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic drive(input logic [15:0] a, input logic rnw, input logic p2, input logic [7:0] d);
      @(negedge clk);
      cpu_addr = a; cpu_rnw = rnw; cpu_phi2 = p2; cpu_wdata = d;
      #2;
   endtask

   // Model update at the edge that follows a driven vector (R5, R10)
   task automatic tick_model();
      if (cpu_phi2 && !cpu_rnw && cpu_addr == 16'h8000) mdl_a = cpu_wdata[3:0];
      if (cpu_phi2 && !cpu_rnw && cpu_addr == 16'h8001) mdl_b = cpu_wdata[3:0];
   endtask

   task automatic check_all();
      logic [1:0] rg;
      logic hit, rd, wr;
      logic [7:0] exp_stb, act_stb;
      rg  = cpu_addr[15:14];
      hit = (cpu_addr == 16'h8000) || (cpu_addr == 16'h8001);
      rd  = cpu_phi2 & cpu_rnw;
      wr  = cpu_phi2 & ~cpu_rnw;
      exp_stb = {rg == 2'd0 && rd, rg == 2'd0 && wr, rg == 2'd1 && rd, rg == 2'd1 && wr,
                 rg == 2'd3 && rd, rg == 2'd2 && !hit && rd, rg == 2'd2 && !hit && wr, hit && rd};
      act_stb = {ram_a_oe, ram_a_we, ram_b_oe, ram_b_we, rom_oe, io_oe, io_we, cpu_rdata_en};
      check("R1 R7 R8 R9 strobes", 32'(act_stb), 32'(exp_stb));
      check("R2 RAM A address", 32'(ram_a_addr), 32'({mdl_a, cpu_addr[13:0]}));
      check("R3 RAM B address", 32'(ram_b_addr), 32'({mdl_b, cpu_addr[13:0]}));
      if (hit && rd)
         check("R6 readback", 32'(cpu_rdata), 32'({4'h0, cpu_addr[0] ? mdl_b : mdl_a}));
   endtask

   initial begin
      int cyc = 0;
      forever begin
         @(posedge clk);
         cyc++;
         if (cyc > 100000) begin
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
         end
      end
   end

   initial begin
      logic [13:0] offs [8];
      offs = '{14'h0000, 14'h0001, 14'h0002, 14'h0100, 14'h1234, 14'h2AAA, 14'h3FFE, 14'h3FFF};
      mdl_a = 4'hF; mdl_b = 4'hF;
      repeat (3) @(negedge clk);
      // R4: reset value visible while reset is held
      check("R4 bank A in reset", 32'(ram_a_addr[17:14]), 32'hF);
      check("R4 bank B in reset", 32'(ram_b_addr[17:14]), 32'hF);
      rst_n = 1'b1;
      drive(16'h8000, 1'b1, 1'b1, 8'h00);
      check("R4 R6 readback A after reset", 32'({cpu_rdata_en, cpu_rdata}), 32'h10F);
      drive(16'h8001, 1'b1, 1'b1, 8'h00);
      check("R4 R6 readback B after reset", 32'({cpu_rdata_en, cpu_rdata}), 32'h10F);

      // R5: every bank value, opposite orders, garbage upper nibble
      for (int b = 0; b < 16; b++) begin
         drive(16'h8000, 1'b0, 1'b1, {4'hA, 4'(b)});
         tick_model();
         drive(16'h8001, 1'b0, 1'b1, {4'h5, 4'(15 - b)});
         tick_model();
         drive(16'h1234, 1'b1, 1'b0, 8'h00);
         check("R5 bank A load", 32'(ram_a_addr[17:14]), 32'(b));
         check("R5 bank B load", 32'(ram_b_addr[17:14]), 32'(15 - b));
         drive(16'h8000, 1'b1, 1'b1, 8'h00);
         check_all();
         drive(16'h8001, 1'b1, 1'b1, 8'h00);
         check_all();
      end

      // R1 R7 R8 R9 R10: sweep regions, offsets, direction and phase
      for (int rg = 0; rg < 4; rg++) begin
         for (int o = 0; o < 8; o++) begin
            for (int m = 0; m < 4; m++) begin
               drive({2'(rg), offs[o]}, m[0], m[1], 8'(o * 29 + rg * 37 + m * 5));
               check_all();
               tick_model();
            end
         end
      end

      // R10: writes outside phase 2 and to a neighbour address leave banks alone
      drive(16'h8000, 1'b0, 1'b0, 8'h03);
      tick_model();
      drive(16'h8002, 1'b0, 1'b1, 8'h07);
      tick_model();
      drive(16'h0000, 1'b1, 1'b0, 8'h00);
      check("R10 bank A held", 32'(ram_a_addr[17:14]), 32'(mdl_a));
      check("R10 bank B held", 32'(ram_b_addr[17:14]), 32'(mdl_b));

      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end
endmodule